// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of four DMA channels is served next. Each channel has an asynchronous hardware request line and a bit in a software request register. A per-channel mask blocks the hardware line but not the software bit. When any request is pending, the arbiter asks the host for the bus on a hold request output. It then waits for hold acknowledge before it grants a channel.

The grant goes to one channel under either fixed or rotating priority. The block drives a per-channel acknowledge whose polarity can be programmed, and it reports the granted channel number with a valid flag. The grant stays in place until the transfer logic outside signals that the service has ended. The number of channels is a parameter and must be a power of two.

Top module: `dma_prio_arb`

## Requirements
- R1: With `cmd_rotate_i` written as 0 (fixed mode), the lowest-numbered pending channel wins; channel 0 is highest and channel 3 is lowest.
- R2: With `cmd_rotate_i` written as 1, after channel k's service ends, channel k+1 (mod 4) has the highest priority and channel k has the lowest. Before any service in this mode, channel 0 is highest.
- R3: When `cmd_req_low_i` is written as 1, a request line counts as active when it is low. After reset, a request is active when it is high.
- R4: When `cmd_ack_high_i` is written as 1, the acknowledge of the granted channel is 1 and all others are 0. After reset, the granted channel's acknowledge is 0 and all others are 1. With no grant, every acknowledge sits at its inactive level.
- R5: Reset sets all mask bits. A masked hardware request never raises `hrq_o`.
- R6: A 1 in `mask_clr_i` clears that channel's mask bit, and a 1 in `mask_set_i` sets it. Set wins if both are given for the same bit.
- R7: A 1 in `swreq_set_i` raises a request for that channel even when the channel is masked. The software bit clears when that channel's service ends.
- R8: `hrq_o` is high whenever a request is pending or a grant is held. No grant and no active acknowledge is issued until `hlda_i` is seen high while `hrq_o` is high.
- R9: A held grant keeps the same channel until `done_i`, even if a higher-priority request arrives.
- R10: Hardware request lines pass two synchronizer flops. A request driven before clock edge 1 leaves `hrq_o` low after edge 2 and sets it high after edge 3.
- R11: `done_i` during a grant ends it on the next edge. With nothing pending, `hrq_o` then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 4 | Asynchronous hardware request lines |
| swreq_set_i | input | 4 | Pulse to set software request bits |
| mask_set_i | input | 4 | Pulse to set mask bits |
| mask_clr_i | input | 4 | Pulse to clear mask bits |
| cmd_we_i | input | 1 | Load the three command bits below |
| cmd_rotate_i | input | 1 | 1 selects rotating priority |
| cmd_req_low_i | input | 1 | 1 makes request lines active low |
| cmd_ack_high_i | input | 1 | 1 makes acknowledges active high |
| hlda_i | input | 1 | Hold acknowledge from the host |
| done_i | input | 1 | Service of the granted channel has ended |
| hrq_o | output | 1 | Hold request to the host |
| dack_o | output | 4 | Per-channel acknowledge, programmable polarity |
| grant_vld_o | output | 1 | A grant is held |
| grant_ch_o | output | 2 | Number of the granted channel |

## Verification
The hardest case to reach is rotating order, because it only shows once a service has moved the priority pointer away from channel 0. The stimulus serves channel 2 alone first. It then raises channels 0, 1 and 3 together and expects the order 3, 0, 1, which fixed mode would never produce. Grant hold is checked by raising channel 0 while channel 1 is granted. Polarity changes are made with all masks set, so the change in line sense cannot create stray grants.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_GRANT} arb_st_e;
endpackage

// File: rtl/dma_req_sync.sv
`timescale 1ns/1ps
module dma_req_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick #(
  parameter  int NCH = 4,
  localparam int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend_i,
  input  logic [CW-1:0]  top_i,   // highest-priority channel
  output logic           any_o,
  output logic [CW-1:0]  win_o
);
  logic [CW-1:0] idx;
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    idx   = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = top_i + CW'(i);  // wraps because NCH is a power of two
      if (!any_o && pend_i[idx]) begin
        any_o = 1'b1;
        win_o = idx;
      end
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
`timescale 1ns/1ps
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter  int NCH = 4,
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] dreq_i,
  input  logic [NCH-1:0] swreq_set_i,
  input  logic [NCH-1:0] mask_set_i,
  input  logic [NCH-1:0] mask_clr_i,
  input  logic           cmd_we_i,
  input  logic           cmd_rotate_i,
  input  logic           cmd_req_low_i,
  input  logic           cmd_ack_high_i,
  input  logic           hlda_i,
  input  logic           done_i,
  output logic           hrq_o,
  output logic [NCH-1:0] dack_o,
  output logic           grant_vld_o,
  output logic [CW-1:0]  grant_ch_o
);
  arb_st_e        st_q;
  logic           rot_q, req_lo_q, ack_hi_q;
  logic [NCH-1:0] mask_q, sw_q, req_s, hw_act, pend, grant_oh, sw_clr;
  logic [CW-1:0]  ch_q, rot_top_q, top, win;
  logic           any, svc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q    <= 1'b0;
      req_lo_q <= 1'b0;
      ack_hi_q <= 1'b0;
    end else if (cmd_we_i) begin
      rot_q    <= cmd_rotate_i;
      req_lo_q <= cmd_req_low_i;
      ack_hi_q <= cmd_ack_high_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= (mask_q & ~mask_clr_i) | mask_set_i;
  end

  assign svc_end = (st_q == ST_GRANT) && done_i;

  always_comb begin
    sw_clr = '0;
    if (svc_end) sw_clr[ch_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= '0;
    else         sw_q <= (sw_q & ~sw_clr) | swreq_set_i;
  end

  dma_req_sync #(.W(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dreq_i),
    .q_o   (req_s)
  );

  assign hw_act = req_s ^ {NCH{req_lo_q}};
  assign pend   = (hw_act & ~mask_q) | sw_q;
  assign top    = rot_q ? rot_top_q : '0;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .pend_i(pend),
    .top_i (top),
    .any_o (any),
    .win_o (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ch_q      <= '0;
      rot_top_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any) st_q <= ST_HOLD;
        ST_HOLD: begin
          if (!any) st_q <= ST_IDLE;
          else if (hlda_i) begin
            st_q <= ST_GRANT;
            ch_q <= win;
          end
        end
        ST_GRANT: begin
          if (done_i) begin
            st_q <= ST_IDLE;
            if (rot_q) rot_top_q <= ch_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    grant_oh = '0;
    if (st_q == ST_GRANT) grant_oh[ch_q] = 1'b1;
  end

  assign hrq_o       = (st_q != ST_IDLE);
  assign grant_vld_o = (st_q == ST_GRANT);
  assign grant_ch_o  = ch_q;
  assign dack_o      = ack_hi_q ? grant_oh : ~grant_oh;
endmodule

// File: rtl/dma_prio_arb_chk.sv
`timescale 1ns/1ps
module dma_prio_arb_chk #(
  parameter  int NCH = 4,
  localparam int CW  = $clog2(NCH)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hlda_i,
  input logic           done_i,
  input logic           hrq_o,
  input logic [NCH-1:0] dack_o,
  input logic           grant_vld_o,
  input logic [CW-1:0]  grant_ch_o,
  input logic           ack_hi_q
);
  // R8
  grant_after_hlda_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_vld_o) |-> $past(hlda_i) && $past(hrq_o));
  // R8
  hrq_during_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> hrq_o);
  // R9
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o && !done_i |=> grant_vld_o && $stable(grant_ch_o));
  // R11
  done_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o && done_i |=> !grant_vld_o);
  // R4
  dack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_vld_o |-> dack_o == (ack_hi_q ? {NCH{1'b0}} : {NCH{1'b1}}));
  // R4
  dack_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> $countones(ack_hi_q ? dack_o : ~dack_o) == 1);
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hlda_i     (hlda_i),
  .done_i     (done_i),
  .hrq_o      (hrq_o),
  .dack_o     (dack_o),
  .grant_vld_o(grant_vld_o),
  .grant_ch_o (grant_ch_o),
  .ack_hi_q   (ack_hi_q)
);

// File: tb/dma_prio_arb_bench.sv
`timescale 1ns/1ps
module dma_prio_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] dreq, swreq, mset, mclr, dack;
  logic       cmd_we, c_rot, c_rlo, c_ahi, hlda, done, hrq, gvld;
  logic [1:0] gch;
  bit         host_auto;
  int         n_chk = 0, n_fail = 0;
  int         exp_ch[$];
  string      exp_rq[$];
  logic       prev_vld;
  int         e_ch;
  string      e_rq;

  always #10 clk = ~clk;

  dma_prio_arb u_dma_prio_arb (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .swreq_set_i(swreq),
    .mask_set_i(mset), .mask_clr_i(mclr), .cmd_we_i(cmd_we),
    .cmd_rotate_i(c_rot), .cmd_req_low_i(c_rlo), .cmd_ack_high_i(c_ahi),
    .hlda_i(hlda), .done_i(done), .hrq_o(hrq), .dack_o(dack),
    .grant_vld_o(gvld), .grant_ch_o(gch)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // host model
  always @(negedge clk) hlda <= host_auto & hrq;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) prev_vld <= 1'b0;
    else begin
      if (gvld && !prev_vld) begin
        if (exp_ch.size() == 0) chk(1'b0, "R1 unexpected grant", gch, 0);
        else begin
          e_ch = exp_ch.pop_front();
          e_rq = exp_rq.pop_front();
          chk(gch == 2'(e_ch), e_rq, gch, e_ch);
        end
      end
      prev_vld <= gvld;
    end
  end

  task automatic push(input int ch, input string rq);
    exp_ch.push_back(ch);
    exp_rq.push_back(rq);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_grant();
    int n = 0;
    while (!gvld && n < 200) begin @(negedge clk); n++; end
    if (!gvld) chk(1'b0, "R8 grant never came", 0, 1);
  endtask

  task automatic serve(input int ch, input logic idle_lvl);
    wait_grant();
    dreq[ch] = idle_lvl;
    cyc(3);
    done = 1'b1;
    cyc(1);
    done = 1'b0;
    cyc(1);
  endtask

  task automatic wr_cmd(input logic r, input logic rl, input logic ah);
    cmd_we = 1'b1; c_rot = r; c_rlo = rl; c_ahi = ah;
    cyc(1);
    cmd_we = 1'b0;
  endtask

  task automatic pulse_mask(input logic [3:0] s, input logic [3:0] c);
    mset = s; mclr = c;
    cyc(1);
    mset = '0; mclr = '0;
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dreq = '0; swreq = '0; mset = '0; mclr = '0;
    cmd_we = 1'b0; c_rot = 1'b0; c_rlo = 1'b0; c_ahi = 1'b0;
    done = 1'b0; host_auto = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(hrq == 1'b0, "R8 reset hrq", hrq, 0);
    chk(dack == 4'hF, "R4 reset dack", dack, 4'hF);
    chk(gvld == 1'b0, "R9 reset grant", gvld, 0);

    // masked after reset
    dreq = 4'b0001;
    cyc(6);
    chk(hrq == 1'b0, "R5 masked request", hrq, 0);
    dreq = '0;
    cyc(3);
    pulse_mask(4'h0, 4'hF);

    // sync latency and fixed order
    dreq = 4'b0110;
    cyc(2);
    chk(hrq == 1'b0, "R10 after two edges", hrq, 0);
    cyc(1);
    chk(hrq == 1'b1, "R10 after three edges", hrq, 1);
    cyc(5);
    chk(dack == 4'hF && gvld == 1'b0, "R8 no grant without hlda", dack, 4'hF);
    push(1, "R1 ch1 before ch2");
    host_auto = 1'b1;
    wait_grant();
    chk(dack == 4'b1101, "R4 active-low dack", dack, 4'b1101);
    dreq[0] = 1'b1;
    cyc(6);
    chk(gvld && gch == 2'd1, "R9 grant held", gch, 1);
    push(0, "R1 ch0 first");
    push(2, "R1 ch2");
    push(3, "R1 ch3");
    dreq[3] = 1'b1;
    serve(1, 1'b0);
    serve(0, 1'b0);
    serve(2, 1'b0);
    serve(3, 1'b0);
    chk(exp_ch.size() == 0, "R1 all grants seen", exp_ch.size(), 0);
    cyc(4);
    chk(hrq == 1'b0, "R11 hrq falls when idle", hrq, 0);

    // rotating
    wr_cmd(1'b1, 1'b0, 1'b0);
    push(2, "R2 ch2 alone");
    push(3, "R2 ch3 after ch2");
    push(0, "R2 ch0 after ch3");
    push(1, "R2 ch1 last");
    dreq = 4'b0100;
    serve(2, 1'b0);
    dreq = 4'b1011;
    serve(3, 1'b0);
    serve(0, 1'b0);
    serve(1, 1'b0);
    chk(exp_ch.size() == 0, "R2 rotation complete", exp_ch.size(), 0);

    // polarity
    pulse_mask(4'hF, 4'h0);
    wr_cmd(1'b0, 1'b1, 1'b1);
    dreq = 4'hF;
    cyc(4);
    chk(dack == 4'h0, "R4 active-high idle", dack, 0);
    pulse_mask(4'h0, 4'hF);
    cyc(4);
    chk(hrq == 1'b0, "R3 high lines inactive", hrq, 0);
    push(2, "R3 active-low request");
    dreq = 4'b1011;
    wait_grant();
    chk(dack == 4'b0100, "R4 active-high dack", dack, 4'b0100);
    serve(2, 1'b1);

    // software request past mask
    pulse_mask(4'hF, 4'h0);
    wr_cmd(1'b0, 1'b0, 1'b0);
    dreq = '0;
    cyc(4);
    chk(hrq == 1'b0, "R5 all masked idle", hrq, 0);
    push(3, "R7 software request");
    swreq = 4'b1000;
    cyc(1);
    swreq = '0;
    serve(3, 1'b0);
    cyc(6);
    chk(hrq == 1'b0, "R7 software bit cleared", hrq, 0);

    // mask writes
    dreq = 4'b0010;
    cyc(6);
    chk(hrq == 1'b0, "R6 masked line", hrq, 0);
    push(1, "R6 mask cleared");
    pulse_mask(4'h0, 4'b0010);
    wait_grant();
    pulse_mask(4'b0010, 4'h0);
    dreq[1] = 1'b1;
    cyc(2);
    done = 1'b1;
    cyc(1);
    done = 1'b0;
    cyc(6);
    chk(hrq == 1'b0, "R6 mask set again", hrq, 0);
    chk(exp_ch.size() == 0, "R6 queue empty", exp_ch.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule